// File: doc/BRIEF.md
# Two-Preset Minute Countdown Timer

This block is a countdown timer with two fixed durations. It runs from a 1 kHz reference clock. A prescaler inside the block divides that clock into a one-second tick. Three keys drive it. The set key chooses between a 20-minute and a 30-minute duration. The start key launches the countdown. The reset key aborts the countdown and returns the block to its power-up condition. The remaining time leaves the block as four BCD digits (tens of minutes, units of minutes, tens of seconds, units of seconds) for a static four-digit display. A buzzer flag rises when the count reaches zero.

The control logic is a three-state machine:

- **IDLE**: the display shows the chosen preset, and each set press flips the choice.
- **RUN**: the count drops by one second per tick.
- **DONE**: the display holds 00:00 and the buzzer is on.

The machine has four transitions:

- **launch**: IDLE to RUN, on a start press.
- **expire**: RUN to DONE, on the tick that takes 00:01 to 00:00.
- **acknowledge**: DONE to IDLE, on a set press.
- **abort**: any state to IDLE, on the reset key.

Set and start pass through a two-flop synchronizer and act only on their rising edge. The reset key is asserted asynchronously and released through its own two-flop synchronizer.

Top module: `preset_countdown`

## Requirements
- R1: After the reset key is released, the block is in IDLE with the 20-minute preset chosen. The digits read 2,0,0,0 and buzzer is 0.
- R2: In IDLE, each set press flips the preset between 20 and 30 minutes. Within a few cycles the digits show the chosen preset as BCD, either 2,0,0,0 or 3,0,0,0.
- R3: After start is acted upon, the digits keep the preset value for TICK_DIV cycles. Each further TICK_DIV cycles then removes one second.
- R4: The count steps down in BCD. Units of seconds run 9 to 0, and tens of seconds run 5 to 0. Going past x:00 borrows one minute and gives x-1:59, including 10:00 to 09:59 and 30:00 to 29:59. No digit ever leaves its BCD range.
- R5: When the count reaches 00:00, it stops and buzzer goes to 1. Buzzer stays at 1 until set is pressed or the reset key is asserted.
- R6: While the count is running, set presses do not change the preset and start presses have no effect. Start presses in DONE also have no effect.
- R7: A set press in DONE clears buzzer and returns the block to IDLE. The preset is not flipped, so the digits show the preset that was last run.
- R8: Asserting the reset key during a countdown ends it at once. The block returns to IDLE with 20:00 shown, the 20-minute preset chosen, and buzzer at 0.
- R9: If set and start rise in the same cycle in IDLE, start wins. The countdown launches from the preset shown before the press, and the set press is dropped.
- R10: A key held high acts only once. Holding set flips the preset a single time, and holding start launches only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 kHz reference clock |
| rst_key | input | 1 | Reset key, active high, asserted asynchronously |
| set_key | input | 1 | Preset toggle and acknowledge key, active high |
| start_key | input | 1 | Start key, active high |
| min_tens | output | 4 | BCD tens of minutes |
| min_ones | output | 4 | BCD units of minutes |
| sec_tens | output | 4 | BCD tens of seconds (0 to 5) |
| sec_ones | output | 4 | BCD units of seconds |
| buzzer | output | 1 | High while expired |

## Verification
Two things can happen in the same cycle:

- **Set and start in IDLE.** The bench raises both keys on the same clock phase, so their synchronized edges arrive together. It then checks that the first displayed value is the preset shown before the press and that the following tick removes one second from that preset.
- **A tick during a key press in RUN.** The bench holds set or start high across random stretches of the countdown, so their edges land among tick cycles. It judges the result by the count still matching its model at every sample, and by the acknowledge in DONE showing that the preset was not flipped.

// File: rtl/countdown_pkg.sv
package countdown_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_state_t;

    typedef struct packed {
        logic [3:0] mt;
        logic [3:0] mu;
        logic [3:0] st;
        logic [3:0] su;
    } mmss_t;

    function automatic mmss_t preset_bcd(input int unsigned minutes);
        mmss_t r;
        r.mt = 4'(minutes / 10);
        r.mu = 4'(minutes % 10);
        r.st = 4'd0;
        r.su = 4'd0;
        return r;
    endfunction

endpackage

// File: rtl/key_conditioner.sv
module key_conditioner #(
    parameter int NKEYS = 2
) (
    input  logic             clk,
    input  logic             rst_key,
    input  logic [NKEYS-1:0] keys,
    output logic [NKEYS-1:0] rises,
    output logic             clr
);
    logic rst_q1;
    logic rst_q2;

    always_ff @(posedge clk or posedge rst_key) begin
        if (rst_key) begin
            rst_q1 <= 1'b1;
            rst_q2 <= 1'b1;
        end else begin
            rst_q1 <= 1'b0;
            rst_q2 <= rst_q1;
        end
    end

    assign clr = rst_q2;

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (clr) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= keys[k];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign rises[k] = sync_q & ~prev_q;

        // R10
        single_rise_chk: assert property (@(posedge clk) disable iff (clr)
            rises[k] |=> !rises[k]);
    end

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (clr)
        tick |=> !tick);

endmodule

// File: rtl/bcd_countdown.sv
module bcd_countdown
    import countdown_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  logic  load,
    input  mmss_t preset,
    input  logic  dec,
    output mmss_t value,
    output logic  at_one
);
    mmss_t cur;
    mmss_t nxt;
    logic  is_zero;

    assign is_zero = (cur == mmss_t'(16'h0000));
    assign at_one  = (cur == mmss_t'(16'h0001));

    always_comb begin
        nxt = cur;
        if (cur.su != 4'd0) begin
            nxt.su = cur.su - 4'd1;
        end else begin
            nxt.su = 4'd9;
            if (cur.st != 4'd0) begin
                nxt.st = cur.st - 4'd1;
            end else begin
                nxt.st = 4'd5;
                if (cur.mu != 4'd0) begin
                    nxt.mu = cur.mu - 4'd1;
                end else begin
                    nxt.mu = 4'd9;
                    nxt.mt = cur.mt - 4'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cur <= '0;
        end else if (load) begin
            cur <= preset;
        end else if (dec && !is_zero) begin
            cur <= nxt;
        end
    end

    assign value = cur;

    // R4
    digit_range_chk: assert property (@(posedge clk) disable iff (clr)
        (cur.st <= 4'd5) && (cur.su <= 4'd9) && (cur.mu <= 4'd9));

    // R5
    zero_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (is_zero && !load) |=> (value == mmss_t'(16'h0000)));

endmodule

// File: rtl/countdown_ctrl.sv
module countdown_ctrl
    import countdown_pkg::*;
#(
    parameter int A_MIN = 20,
    parameter int B_MIN = 30
) (
    input  logic  clk,
    input  logic  clr,
    input  logic  set_edge,
    input  logic  start_edge,
    input  logic  tick,
    input  logic  at_one,
    output logic  load,
    output mmss_t preset,
    output logic  run,
    output logic  buzzer
);
    localparam mmss_t PRESET_A = preset_bcd(A_MIN);
    localparam mmss_t PRESET_B = preset_bcd(B_MIN);

    ctl_state_t state;
    ctl_state_t state_nxt;
    logic       mode_b;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start_edge)    state_nxt = ST_RUN;
            ST_RUN:  if (tick && at_one) state_nxt = ST_DONE;
            ST_DONE: if (set_edge)      state_nxt = ST_IDLE;
            default:                    state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state  <= ST_IDLE;
            mode_b <= 1'b0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE && set_edge && !start_edge) begin
                mode_b <= ~mode_b;
            end
        end
    end

    always_comb begin
        load   = 1'b0;
        run    = 1'b0;
        buzzer = 1'b0;
        unique case (state)
            ST_IDLE: load   = 1'b1;
            ST_RUN:  run    = 1'b1;
            ST_DONE: buzzer = 1'b1;
            default: load   = 1'b1;
        endcase
    end

    assign preset = mode_b ? PRESET_B : PRESET_A;

    // R6
    set_ignored_run_chk: assert property (@(posedge clk) disable iff (clr)
        (state == ST_RUN && set_edge) |=> $stable(mode_b));

    // R9
    start_priority_chk: assert property (@(posedge clk) disable iff (clr)
        (state == ST_IDLE && start_edge && set_edge) |=> (state == ST_RUN && $stable(mode_b)));

    // R5
    buzzer_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (buzzer && !set_edge) |=> buzzer);

    // R7
    ack_keeps_mode_chk: assert property (@(posedge clk) disable iff (clr)
        (state == ST_DONE && set_edge) |=> (state == ST_IDLE && $stable(mode_b)));

endmodule

// File: rtl/preset_countdown.sv
module preset_countdown
    import countdown_pkg::*;
#(
    parameter int TICK_DIV = 1000,
    parameter int A_MIN    = 20,
    parameter int B_MIN    = 30
) (
    input  logic       clk,
    input  logic       rst_key,
    input  logic       set_key,
    input  logic       start_key,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_ones,
    output logic       buzzer
);
    localparam int NKEYS = 2;

    logic [NKEYS-1:0] rises;
    logic             clr;
    logic             tick;
    logic             load;
    logic             run;
    logic             at_one;
    mmss_t            preset;
    mmss_t            value;

    key_conditioner #(.NKEYS(NKEYS)) u_keys (
        .clk     (clk),
        .rst_key (rst_key),
        .keys    ({start_key, set_key}),
        .rises   (rises),
        .clr     (clr)
    );

    tick_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk  (clk),
        .clr  (clr),
        .run  (run),
        .tick (tick)
    );

    countdown_ctrl #(.A_MIN(A_MIN), .B_MIN(B_MIN)) u_ctrl (
        .clk        (clk),
        .clr        (clr),
        .set_edge   (rises[0]),
        .start_edge (rises[1]),
        .tick       (tick),
        .at_one     (at_one),
        .load       (load),
        .preset     (preset),
        .run        (run),
        .buzzer     (buzzer)
    );

    bcd_countdown u_count (
        .clk    (clk),
        .clr    (clr),
        .load   (load),
        .preset (preset),
        .dec    (tick),
        .value  (value),
        .at_one (at_one)
    );

    assign min_tens = value.mt;
    assign min_ones = value.mu;
    assign sec_tens = value.st;
    assign sec_ones = value.su;

endmodule

// File: tb/test_preset_countdown.sv
module test_preset_countdown;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    logic       clk = 1'b0;
    logic       rst_key;
    logic       set_key;
    logic       start_key;
    logic [3:0] min_tens, min_ones, sec_tens, sec_ones;
    logic       buzzer;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    preset_countdown #(.TICK_DIV(DIV), .A_MIN(20), .B_MIN(30)) i_preset_countdown (
        .clk(clk), .rst_key(rst_key), .set_key(set_key), .start_key(start_key),
        .min_tens(min_tens), .min_ones(min_ones), .sec_tens(sec_tens),
        .sec_ones(sec_ones), .buzzer(buzzer)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] exp_digits(input int s);
        int m;
        int sc;
        m  = s / 60;
        sc = s % 60;
        return {4'(m / 10), 4'(m % 10), 4'(sc / 10), 4'(sc % 10)};
    endfunction

    function automatic logic [15:0] shown();
        return {min_tens, min_ones, sec_tens, sec_ones};
    endfunction

    task automatic check_val(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: buzzer actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_set(input int hold);
        set_key = 1'b1;
        wait_n(hold);
        set_key = 1'b0;
        wait_n(6);
    endtask

    task automatic press_start_short();
        start_key = 1'b1;
        wait_n(4);
        start_key = 1'b0;
        wait_n(6);
    endtask

    task automatic do_reset();
        rst_key = 1'b1;
        wait_n(3);
        rst_key = 1'b0;
        wait_n(6);
    endtask

    // Launches from IDLE and runs to expiry, checking at random points.
    task automatic start_and_run(input int pm, input bit with_set, input string tag);
        int total;
        int elapsed;
        int n;
        start_key = 1'b1;
        set_key   = with_set;
        wait_n(3 + DIV/2);
        check_val({tag, " R3 preset held"}, shown(), exp_digits(pm * 60));
        check_bit({tag, " R3 buzzer low"}, buzzer, 1'b0);
        start_key = 1'b0;
        set_key   = 1'b0;
        total   = pm * 60;
        elapsed = 0;
        wait_n(DIV);
        elapsed = 1;
        check_val({tag, " R3 first second"}, shown(), exp_digits(total - 1));
        while (elapsed < total) begin
            n = 1 + int'($urandom % 97);
            if (n > total - elapsed) n = total - elapsed;
            if (n < total - elapsed) begin
                if ($urandom % 4 == 0) set_key = 1'b1;
                else if ($urandom % 4 == 0) start_key = 1'b1;
            end
            wait_n(n * DIV);
            set_key   = 1'b0;
            start_key = 1'b0;
            elapsed += n;
            check_val({tag, " R4 R6 count"}, shown(), exp_digits(total - elapsed));
            check_bit({tag, " R5 buzzer"}, buzzer, elapsed == total);
        end
        // Crossing points
    endtask

    initial begin
        int np;
        bit mode30;
        rst_key   = 1'b1;
        set_key   = 1'b0;
        start_key = 1'b0;
        void'($urandom(32'd20240326));
        wait_n(4);
        rst_key = 1'b0;
        wait_n(6);
        check_val("R1 reset digits", shown(), 16'h2000);
        check_bit("R1 reset buzzer", buzzer, 1'b0);

        press_set(4);
        check_val("R2 set to 30", shown(), 16'h3000);
        press_set(4);
        check_val("R2 set back to 20", shown(), 16'h2000);
        press_set(40);
        check_val("R10 held set flips once", shown(), 16'h3000);
        press_set(4);
        mode30 = 1'b0;
        np = 1 + int'($urandom % 5);
        for (int i = 0; i < np; i++) begin
            press_set(3 + int'($urandom % 6));
            mode30 = ~mode30;
            check_val("R2 random set presses", shown(), mode30 ? 16'h3000 : 16'h2000);
        end
        if (mode30) press_set(4);
        check_val("R2 back at 20", shown(), 16'h2000);

        // R9: set and start together, 20-minute run
        start_and_run(20, 1'b1, "run20");
        wait_n(60);
        check_val("R5 held at zero", shown(), 16'h0000);
        check_bit("R5 buzzer stays", buzzer, 1'b1);
        press_start_short();
        check_val("R6 start in done", shown(), 16'h0000);
        check_bit("R6 start in done buzzer", buzzer, 1'b1);
        press_set(4);
        check_bit("R7 ack clears buzzer", buzzer, 1'b0);
        check_val("R7 ack keeps preset 20", shown(), 16'h2000);

        // 30-minute run, cleared by reset key
        press_set(4);
        check_val("R2 chose 30", shown(), 16'h3000);
        start_and_run(30, 1'b0, "run30");
        do_reset();
        check_bit("R5 reset clears buzzer", buzzer, 1'b0);
        check_val("R8 reset after done", shown(), 16'h2000);

        // Abort mid-run
        press_set(4);
        start_key = 1'b1;
        wait_n(3 + DIV/2 + 5 * DIV);
        start_key = 1'b0;
        check_val("R4 30:00 to 29:55", shown(), exp_digits(30 * 60 - 5));
        do_reset();
        check_val("R8 abort digits", shown(), 16'h2000);
        check_bit("R8 abort buzzer", buzzer, 1'b0);
        start_key = 1'b1;
        wait_n(3 + DIV/2 + DIV);
        start_key = 1'b0;
        check_val("R8 mode is 20 after abort", shown(), exp_digits(20 * 60 - 1));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule